// File: doc/BRIEF.md
# Two-Register Byte Processor Core

This block is a small 8-bit processor core with two byte-wide general registers, `r0` and `r1`. It has separate memories for instructions and data. Instructions come from an external read-only program store through an address/instruction port. Data lives in a 256-byte read-write RAM model held inside the core. The RAM's port signals are driven out so that a testbench or a neighbouring block can watch every access. The program store cannot be written, and instruction fetch never touches the data RAM.

Each legal instruction finishes in one clock cycle. The one exception is a byte load, which takes two cycles so that the registered RAM read can return before the register is written. The instruction set covers register-register arithmetic (add, subtract, multiply, divide), shifts by a register amount, conditional jumps on a register being zero or non-zero, and loads and stores at an 8-bit absolute address. There is no stack, no call or return and no indirect addressing. Any encoding outside the defined set stops the core: the halt output goes high and the program counter freezes until the next reset.

Top module: `tworeg_cpu`

## Requirements
- R1: A low `rst_n` sampled at a clock edge clears the program counter and both registers, so the first fetch after reset is from address 0 and a store of either register before any write stores 0x00.
- R2: ADD and SUB write `first + second` and `first - second`, wrapped modulo 256, into the first register.
- R3: MUL writes the low byte of the 16-bit product of the two registers into the first register.
- R4: DIV writes the truncated quotient `first / second` into the first register; a zero divisor writes 0xFF.
- R5: SHL and SHR shift the first register left or right by the unsigned amount in the second register and fill with zeros; an amount of 8 or more gives 0x00.
- R6: JZ loads the program counter with the 8-bit immediate when the first register is zero; otherwise the next fetch is from the following address. The jump takes one cycle.
- R7: JNZ loads the program counter with the immediate when the first register is non-zero; otherwise execution falls through.
- R8: LB occupies two cycles at the same fetch address and then places the RAM byte at the immediate address into the first register.
- R9: SB takes one cycle, with `dmem_we` high, `dmem_addr` equal to the immediate and `dmem_wdata` equal to the first register. A later LB of that address returns the stored byte.
- R10: An opcode from 10 to 15, or a non-zero value in bits [9:8], halts the core: `halt` is high, the fetch address holds, and no store is made.
- R11: Each instruction is 16 bits wide. Bits [15:12] hold the opcode (ADD=0, SUB=1, MUL=2, DIV=3, SHL=4, SHR=5, JZ=6, JNZ=7, LB=8, SB=9), bits [9:8] must be zero, and bits [7:0] hold the immediate.
- R12: Bit 11 selects the first register and bit 10 selects the second (0 selects `r0`, 1 selects `r1`). Each instruction writes at most one register, and it may name the same register twice.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 8 | Program-store fetch address (the program counter) |
| imem_data | input | 16 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 8 | Data RAM address (the instruction immediate) |
| dmem_wdata | output | 8 | Byte written by a store |
| dmem_we | output | 1 | High during the cycle of a store |
| dmem_rdata | output | 8 | Registered RAM read data |
| halt | output | 1 | High while the current instruction is illegal and the core is stopped |

## Verification
The assertions assume that `imem_data` is a function of `imem_addr` only and stays stable within a cycle. This holds because the program store is read-only and combinational. They also assume that `rst_n` is low at the first clock edge. The bench keeps to both conditions: it changes program contents only while reset is held, and it starts every run from reset. Registers can only be loaded from RAM, and RAM can only be written from registers, so every operand value is built by the program itself. A divide by zero gives 0xFF and a subtraction then gives 1, and each operand is then assembled bit by bit with doublings and additions before the operation under test.

// File: rtl/tworeg_pkg.sv
// Package: shared encodings for the two-register core.
// Assumes a 16-bit instruction with a 4-bit opcode in the top bits.
package tworeg_pkg;

    localparam int OPC_W = 4;
    localparam int IMM_W = 8;
    localparam int RSV_W = 2;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_MUL = 4'd2,
        OP_DIV = 4'd3,
        OP_SHL = 4'd4,
        OP_SHR = 4'd5,
        OP_JZ  = 4'd6,
        OP_JNZ = 4'd7,
        OP_LB  = 4'd8,
        OP_SB  = 4'd9
    } opcode_e;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_LOAD = 1'b1
    } core_state_e;

    typedef struct packed {
        opcode_e          op;
        logic             rd;
        logic             rs;
        logic [IMM_W-1:0] imm;
        logic             illegal;
    } decoded_t;

endpackage

// File: rtl/tc_decode.sv
// Module: instruction field splitter.
// Splits a word into opcode, register selects and immediate. It flags an
// unused opcode or non-zero reserved bits as illegal. Purely combinational.
module tc_decode
    import tworeg_pkg::*;
#(
    parameter int INSTR_W = 16
) (
    input  logic [INSTR_W-1:0] instr,
    output decoded_t           dec
);

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int RD_BIT  = OPC_LSB - 1;
    localparam int RS_BIT  = OPC_LSB - 2;
    localparam int RSV_LSB = IMM_W;

    logic [OPC_W-1:0] opc;
    logic [RSV_W-1:0] rsv;
    logic             opc_known;

    // Slice the fixed fields out of the word.
    always_comb begin
        opc     = instr[INSTR_W-1:OPC_LSB];
        rsv     = instr[RSV_LSB+RSV_W-1:RSV_LSB];
        dec.op  = opcode_e'(opc);
        dec.rd  = instr[RD_BIT];
        dec.rs  = instr[RS_BIT];
        dec.imm = instr[IMM_W-1:0];
    end

    // Classify the opcode; anything past store is unused.
    always_comb begin
        case (opc)
            OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_SHL,
            OP_SHR, OP_JZ, OP_JNZ, OP_LB, OP_SB: opc_known = 1'b1;
            default:                             opc_known = 1'b0;
        endcase
        dec.illegal = !opc_known || (rsv != '0);
    end

endmodule

// File: rtl/tc_alu.sv
// Module: byte arithmetic unit.
// Computes the register-register result for the arithmetic and shift
// opcodes. All results wrap to DATA_W bits. Other opcodes pass a through.
module tc_alu
    import tworeg_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);

    localparam logic [DATA_W-1:0] SH_LIMIT = DATA_W[DATA_W-1:0];

    logic [2*DATA_W-1:0] prod;

    // Full product; only the low half is kept.
    always_comb prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};

    // Select the result for the current opcode.
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_MUL:  y = prod[DATA_W-1:0];
            OP_DIV:  y = (b == '0) ? '1 : a / b;
            OP_SHL:  y = (b >= SH_LIMIT) ? '0 : a << b;
            OP_SHR:  y = (b >= SH_LIMIT) ? '0 : a >> b;
            default: y = a;
        endcase
    end

endmodule

// File: rtl/tc_regfile.sv
// Module: general register bank.
// Holds NREG registers with one write port. Every register is visible
// at once on regs_o. Reset clears every register.
module tc_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 2,
    parameter int SEL_W  = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [SEL_W-1:0]             waddr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [NREG-1:0][DATA_W-1:0]  regs_o
);

    logic [NREG-1:0] we_vec;

    // One write strobe per register.
    generate
        for (genvar g = 0; g < NREG; g++) begin : g_sel
            assign we_vec[g] = we && (waddr == SEL_W'(g));
        end
    endgenerate

    // Register update: clear on reset, else write the strobed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_o <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (we_vec[i]) regs_o[i] <= wdata;
            end
        end
    end

    assert_single_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(we_vec));

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (regs_o == '0));

endmodule

// File: rtl/tc_dram.sv
// Module: data RAM model, 2**ADDR_W bytes, one port.
// Write is synchronous. Read data is registered and appears one cycle
// after the address; a read of the address being written returns the old byte.
module tc_dram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Storage write and registered read.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        rdata <= mem[addr];
    end

endmodule

// File: rtl/tworeg_cpu.sv
// Module: two-register byte processor, top level.
// Fetches from an external read-only store and executes one instruction
// per cycle. Loads take an extra cycle. The data RAM is internal.
// Assumes imem_data depends only on imem_addr.
module tworeg_cpu
    import tworeg_pkg::*;
#(
    parameter int PC_W    = 8,
    parameter int DATA_W  = 8,
    parameter int DADDR_W = 8,
    parameter int INSTR_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [PC_W-1:0]    imem_addr,
    input  logic [INSTR_W-1:0] imem_data,
    output logic [DADDR_W-1:0] dmem_addr,
    output logic [DATA_W-1:0]  dmem_wdata,
    output logic               dmem_we,
    output logic [DATA_W-1:0]  dmem_rdata,
    output logic               halt
);

    localparam int             NREG     = 2;
    localparam int             SEL_W    = 1;
    localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);
    localparam logic [DATA_W-1:0] SH_LIMIT = DATA_W[DATA_W-1:0];

    decoded_t                      dec;
    core_state_e                   state_q, state_next;
    logic [PC_W-1:0]               pc_q, pc_next;
    logic [NREG-1:0][DATA_W-1:0]   regs;
    logic [DATA_W-1:0]             rd_val, rs_val, alu_y, rf_wdata;
    logic                          is_alu, jump_taken, rf_we, running;

    tc_decode #(.INSTR_W(INSTR_W)) u_decode (
        .instr (imem_data),
        .dec   (dec)
    );

    tc_alu #(.DATA_W(DATA_W)) u_alu (
        .op (dec.op),
        .a  (rd_val),
        .b  (rs_val),
        .y  (alu_y)
    );

    tc_regfile #(.DATA_W(DATA_W), .NREG(NREG), .SEL_W(SEL_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (rf_we),
        .waddr  (dec.rd),
        .wdata  (rf_wdata),
        .regs_o (regs)
    );

    tc_dram #(.DATA_W(DATA_W), .ADDR_W(DADDR_W)) u_dram (
        .clk   (clk),
        .addr  (dmem_addr),
        .we    (dmem_we),
        .wdata (dmem_wdata),
        .rdata (dmem_rdata)
    );

    // Operand read and instruction class flags.
    always_comb begin
        rd_val     = regs[dec.rd];
        rs_val     = regs[dec.rs];
        running    = (state_q == ST_RUN) && !dec.illegal;
        is_alu     = running && (dec.op inside {OP_ADD, OP_SUB, OP_MUL,
                                                OP_DIV, OP_SHL, OP_SHR});
        jump_taken = running && (((dec.op == OP_JZ)  && (rd_val == '0)) ||
                                 ((dec.op == OP_JNZ) && (rd_val != '0)));
    end

    // Next program counter and phase.
    always_comb begin
        pc_next    = pc_q;
        state_next = state_q;
        if (state_q == ST_LOAD) begin
            pc_next    = pc_q + PC_STEP;
            state_next = ST_RUN;
        end else if (!dec.illegal) begin
            if (dec.op == OP_LB)  state_next = ST_LOAD;
            else if (jump_taken)  pc_next    = dec.imm[PC_W-1:0];
            else                  pc_next    = pc_q + PC_STEP;
        end
    end

    // Register write-back and data RAM port.
    always_comb begin
        rf_we      = is_alu || (state_q == ST_LOAD);
        rf_wdata   = (state_q == ST_LOAD) ? dmem_rdata : alu_y;
        dmem_addr  = dec.imm[DADDR_W-1:0];
        dmem_wdata = rd_val;
        dmem_we    = running && (dec.op == OP_SB);
        halt       = dec.illegal;
        imem_addr  = pc_q;
    end

    // Program counter and phase registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            state_q <= ST_RUN;
        end else begin
            pc_q    <= pc_next;
            state_q <= state_next;
        end
    end

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> (imem_addr == '0));

    assert_div_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dec.op == OP_DIV && rs_val == '0)
        |=> (regs[$past(dec.rd)] == '1));

    assert_wide_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (dec.op == OP_SHL || dec.op == OP_SHR) && rs_val >= SH_LIMIT)
        |=> (regs[$past(dec.rd)] == '0));

    assert_jz_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dec.op == OP_JZ && rd_val == '0)
        |=> (imem_addr == $past(dec.imm[PC_W-1:0])));

    assert_jnz_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dec.op == OP_JNZ && rd_val == '0)
        |=> (imem_addr == $past(imem_addr) + PC_STEP));

    assert_load_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && dec.op == OP_LB) |=> (state_q == ST_LOAD && $stable(imem_addr)));

    assert_load_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOAD)
        |=> (state_q == ST_RUN && imem_addr == $past(imem_addr) + PC_STEP));

    assert_store_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |=> (imem_addr == $past(imem_addr) + PC_STEP));

    assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> ($stable(imem_addr) && halt));

    assert_halt_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> !dmem_we);

endmodule

// File: tb/tworeg_cpu_bench.sv
// Bench: builds each program in a bench-side program store and runs it from
// reset. It records stores and fetch-address visits at the falling edge
// and compares them against arithmetic expectations.
module tworeg_cpu_bench;

    localparam logic [3:0] C_ADD = 4'd0, C_SUB = 4'd1, C_MUL = 4'd2, C_DIV = 4'd3,
                           C_SHL = 4'd4, C_SHR = 4'd5, C_JZ = 4'd6, C_JNZ = 4'd7,
                           C_LB = 4'd8, C_SB = 4'd9;
    localparam logic [15:0] W_HALT = 16'hF000;
    localparam logic [7:0]  ONE_AT = 8'hF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  imem_addr;
    logic [15:0] imem_data;
    logic [7:0]  dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, halt;

    logic [15:0] rom [256];
    int          pp;
    int          total = 0;
    int          bad = 0;
    int          cyc = 0;
    int          st_val [256];
    bit          st_seen [256];
    int          visits [256];
    int          st_cnt;
    int          first_pc;
    bit          halted;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign imem_data = rom[imem_addr];

    tworeg_cpu u_tworeg_cpu (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_rdata(dmem_rdata), .halt(halt)
    );

    // Observe stores and fetch addresses between edges.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!halt) visits[imem_addr] = visits[imem_addr] + 1;
            if (dmem_we) begin
                st_val[dmem_addr]  = int'(dmem_wdata);
                st_seen[dmem_addr] = 1'b1;
                st_cnt             = st_cnt + 1;
            end
        end
    end

    task automatic check(string req, int act, int exp, string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(logic [3:0] op, logic rd, logic rs, logic [7:0] imm);
        return {op, rd, rs, 2'b00, imm};
    endfunction

    function automatic int expect_op(logic [3:0] op, int a, int b);
        case (op)
            C_ADD:   return (a + b) % 256;
            C_SUB:   return (a - b + 256) % 256;
            C_MUL:   return (a * b) % 256;
            C_DIV:   return (b == 0) ? 255 : a / b;
            C_SHL:   return (b >= 8) ? 0 : (a * (1 << b)) % 256;
            default: return (b >= 8) ? 0 : a / (1 << b);
        endcase
    endfunction

    task automatic emit(logic [15:0] w);
        rom[pp] = w;
        pp++;
    endtask

    task automatic new_prog();
        for (int i = 0; i < 256; i++) rom[i] = W_HALT;
        pp = 0;
    endtask

    // r1 = 0/0 = 0xFF, r0 = 0 - 0xFF = 1, keep 1 at ONE_AT.
    task automatic preamble();
        emit(enc(C_DIV, 1'b1, 1'b0, 8'h00));
        emit(enc(C_SUB, 1'b0, 1'b1, 8'h00));
        emit(enc(C_SB,  1'b0, 1'b0, ONE_AT));
    endtask

    // Build value v in r0 by doubling and adding one (r1 used as temp).
    task automatic build_r0(int v);
        emit(enc(C_SUB, 1'b0, 1'b0, 8'h00));
        for (int i = 7; i >= 0; i--) begin
            emit(enc(C_ADD, 1'b0, 1'b0, 8'h00));
            if (((v >> i) & 1) == 1) begin
                emit(enc(C_LB,  1'b1, 1'b0, ONE_AT));
                emit(enc(C_ADD, 1'b0, 1'b1, 8'h00));
            end
        end
    endtask

    task automatic run_prog();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            st_val[i] = -1; st_seen[i] = 1'b0; visits[i] = 0;
        end
        st_cnt = 0;
        halted = 1'b0;
        @(posedge clk);
        @(posedge clk);
        #1 rst_n = 1'b1;
        for (int n = 0; n < 600; n++) begin
            @(negedge clk);
            if (n == 0) first_pc = int'(imem_addr);
            if (halt) begin halted = 1'b1; break; end
        end
        #1;
        check("R10", int'(halted), 1, "program reached halt");
    endtask

    task automatic arith_run(logic [3:0] op, int a, int b, bit sw);
        new_prog();
        preamble();
        build_r0(a);
        emit(enc(C_SB, 1'b0, 1'b0, 8'h10));
        build_r0(b);
        emit(enc(C_SB, 1'b0, 1'b0, 8'h11));
        if (!sw) begin
            emit(enc(C_LB, 1'b1, 1'b0, 8'h11));
            emit(enc(C_LB, 1'b0, 1'b0, 8'h10));
            emit(enc(op,   1'b0, 1'b1, 8'h00));
            emit(enc(C_SB, 1'b0, 1'b0, 8'h20));
        end else begin
            emit(enc(C_LB, 1'b0, 1'b0, 8'h11));
            emit(enc(C_LB, 1'b1, 1'b0, 8'h10));
            emit(enc(op,   1'b1, 1'b0, 8'h00));
            emit(enc(C_SB, 1'b1, 1'b0, 8'h20));
        end
        run_prog();
        check("R9", st_val[8'h10], a, "stored operand byte");
        case (op)
            C_ADD, C_SUB: check(sw ? "R2 R12" : "R2", st_val[8'h20], expect_op(op, a, b), "add/sub result");
            C_MUL:        check(sw ? "R3 R12" : "R3", st_val[8'h20], expect_op(op, a, b), "mul result");
            C_DIV:        check(sw ? "R4 R12" : "R4", st_val[8'h20], expect_op(op, a, b), "div result");
            default:      check(sw ? "R5 R12" : "R5", st_val[8'h20], expect_op(op, a, b), "shift result");
        endcase
    endtask

    task automatic jump_run(logic [3:0] op, bit reg_sel, bit make_zero);
        bit taken;
        new_prog();
        emit(enc(C_DIV, 1'b1, 1'b0, 8'h00));
        emit(enc(C_SUB, 1'b0, 1'b1, 8'h00));
        emit(make_zero ? enc(C_SUB, reg_sel, reg_sel, 8'h00) : enc(C_ADD, 1'b1, 1'b1, 8'h00));
        emit(enc(op, reg_sel, 1'b0, 8'h40));
        emit(enc(C_SB, 1'b1, 1'b0, 8'h51));
        rom[8'h40] = enc(C_SB, 1'b1, 1'b0, 8'h52);
        run_prog();
        taken = (op == C_JZ) ? make_zero : !make_zero;
        check(op == C_JZ ? "R6" : "R7", int'(st_seen[8'h52]), int'(taken), "jump target reached");
        check(op == C_JZ ? "R6" : "R7", int'(st_seen[8'h51]), int'(!taken), "fall-through reached");
        check(op == C_JZ ? "R6" : "R7", visits[3], 1, "jump single cycle");
    endtask

    initial begin
        int alist [12] = '{0, 1, 2, 3, 7, 8, 15, 16, 100, 128, 200, 255};
        int blist [12] = '{0, 1, 2, 3, 7, 8, 9, 15, 16, 100, 200, 255};
        logic [3:0] ops [6] = '{C_ADD, C_SUB, C_MUL, C_DIV, C_SHL, C_SHR};

        // R1: leave registers non-zero, then reset and store both at once.
        arith_run(C_ADD, 200, 7, 1'b0);
        new_prog();
        emit(enc(C_SB, 1'b0, 1'b0, 8'h30));
        emit(enc(C_SB, 1'b1, 1'b0, 8'h31));
        run_prog();
        check("R1", first_pc, 0, "first fetch address after reset");
        check("R1", st_val[8'h30], 0, "r0 after reset");
        check("R1", st_val[8'h31], 0, "r1 after reset");

        // R2..R5 and R12: sweep operand pairs for every arithmetic opcode.
        for (int o = 0; o < 6; o++)
            for (int ia = 0; ia < 12; ia++)
                for (int ib = 0; ib < 12; ib++)
                    arith_run(ops[o], alist[ia], blist[ib], ((ia + ib) % 2) == 1);

        // R6, R7: both jumps, both registers, zero and non-zero.
        for (int r = 0; r < 2; r++)
            for (int z = 0; z < 2; z++) begin
                jump_run(C_JZ,  r[0], z[0]);
                jump_run(C_JNZ, r[0], z[0]);
            end

        // R8, R9: load timing and store/load round trip.
        new_prog();
        preamble();
        emit(enc(C_LB, 1'b1, 1'b0, ONE_AT));
        emit(enc(C_SB, 1'b1, 1'b0, 8'h60));
        run_prog();
        check("R8", visits[3], 2, "load holds fetch address two cycles");
        check("R8", visits[4], 1, "instruction after load fetched once");
        check("R8", st_val[8'h60], 1, "loaded byte");
        check("R9", visits[2], 1, "store single cycle");
        check("R9", st_val[ONE_AT], 1, "store address and data");

        // R10, R11: unused opcodes and reserved bits halt with no store.
        for (int opc = 10; opc < 17; opc++) begin
            new_prog();
            rom[0] = (opc == 16) ? (enc(C_SB, 1'b0, 1'b0, 8'h70) | 16'h0100)
                                 : {opc[3:0], 12'h000};
            rom[1] = enc(C_SB, 1'b0, 1'b0, 8'h70);
            run_prog();
            repeat (4) @(negedge clk);
            #1;
            check("R10 R11", int'(imem_addr), 0, "fetch address frozen at halt");
            check("R10", int'(halt), 1, "halt stays high");
            check("R10", st_cnt, 0, "no store while halted");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        wait (cyc >= 190000);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule